// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block holds a 256-bit secret that is unique to each device. The secret is set when the design is built and is given to the block as a parameter, so each device can receive a different value without any other change. A simple bus with a chip select, a write enable, a word address and a 32-bit read-data port exposes the secret as eight 32-bit words. The word address is `0x10 + i` for word `i`, and word `i` holds bits `[32*i+31 : 32*i]` of the secret parameter.

A word is released only when three conditions are all met: the mode input is low, which marks firmware as running; the access is a read; and the word has not yet been released since the last reset. Every word has a sticky flag. The first permitted read of a word sets its flag. The flag also serves as the top address bit of a per-bit lookup whose upper half holds only zeros. After the flag is set, every later read of that word comes from the zero half. Holding chip select high therefore exposes the word for one cycle only.

Read data is registered. It appears in the cycle after the access and is zero in every cycle that does not follow a permitted first read.

Top module: `secret_vault`

## Requirements
- R1: The first read of word `i` at address `0x10+i`, with write enable low and mode low, returns `SECRET[32*i +: 32]` on `rdata_o` in the next cycle.
- R2: A later read of a word that has already been released returns all zeros, for as long as no reset occurs.
- R3: If chip select stays high on one word address for several cycles, the real word appears in the first result cycle only, and every later result is zero.
- R4: A read made while `sys_mode_i` is high returns zero and does not use up the word, so a later firmware-mode read still returns the real value.
- R5: An access to any address outside `0x10`..`0x17` returns zero and changes no flag. This holds for addresses whose low three bits match a valid word.
- R6: An access with `wr_en_i` high returns zero and changes no flag, even inside the secret range.
- R7: When `cs_i` is low, `rdata_o` is zero in the next cycle.
- R8: Synchronous active-low reset clears every flag and clears `rdata_o` to zero. After reset, every word can be read once more.
- R9: Each word has its own flag. Reading the words in any order releases each of them exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_en_i | input | 1 | Write enable (writes are ignored) |
| addr_i | input | 8 | Word address |
| sys_mode_i | input | 1 | High while application code runs; blocks release |
| rdata_o | output | 32 | Registered read data |

## Verification
The bench keeps the default window of eight words starting at `0x10`. It overrides the secret with a pattern in which every word is distinct and nonzero, with set bits in all 32 lanes. This lets a wrong word index, a swapped bit lane or a released zero word show up as a mismatch. The bench also probes addresses `0x18`..`0x1F` and `0x08`..`0x0F`. Their low three bits alias real words, so any decoder that compares only the low bits is caught. The reset sequence is run more than once, which exercises flag clearing after every word has been used.

// File: rtl/secret_vault_pkg.sv
package secret_vault_pkg;

    // Classification of the access presented in the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_GRANT  = 2'd1,
        ACC_REFUSE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/svlt_addr_dec.sv
module svlt_addr_dec
    import secret_vault_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_WORDS = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
    localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              cs_i,
    input  logic              wr_en_i,
    input  logic              sys_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int unsigned SPAN_W = ADDR_W + 1;

    logic [SPAN_W-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = {1'b0, addr_i} - {1'b0, BASE_ADDR};
        in_window = (addr_i >= BASE_ADDR) &&
                    (offset < SPAN_W'(NUM_WORDS));
        idx_o     = offset[IDX_W-1:0];
        if (!cs_i) begin
            kind_o = ACC_IDLE;
        end else if (wr_en_i || sys_mode_i || !in_window) begin
            kind_o = ACC_REFUSE;
        end else begin
            kind_o = ACC_GRANT;
        end
    end

endmodule

// File: rtl/svlt_lut_bit.sv
module svlt_lut_bit #(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned TBL_N    = 1 << (IDX_W + 1)
) (
    input  logic [NUM_WORDS-1:0] column_i,  // this bit lane of every word
    input  logic                 used_i,    // top lookup address bit
    input  logic [IDX_W-1:0]     idx_i,
    output logic                 bit_o
);

    logic [TBL_N-1:0] table_v;

    always_comb begin
        table_v = '0;                         // upper half stays zero
        table_v[NUM_WORDS-1:0] = column_i;
        bit_o = table_v[{used_i, idx_i}];
    end

endmodule

// File: rtl/secret_vault.sv
module secret_vault
    import secret_vault_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
    parameter logic [NUM_WORDS*DATA_W-1:0] SECRET = {NUM_WORDS{32'h5AC3_96E1}}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sys_mode_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    typedef struct packed {
        logic [NUM_WORDS-1:0] used;
        logic [DATA_W-1:0]    rdata;
    } state_t;

    state_t state_d, state_q;

    acc_kind_e            kind;
    logic [IDX_W-1:0]     idx;
    logic [NUM_WORDS-1:0] used_q;
    logic                 used_sel;
    logic [DATA_W-1:0]    lut_word;

    assign used_q = state_q.used;

    svlt_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .cs_i      (cs_i),
        .wr_en_i   (wr_en_i),
        .sys_mode_i(sys_mode_i),
        .addr_i    (addr_i),
        .kind_o    (kind),
        .idx_o     (idx)
    );

    always_comb begin
        used_sel = 1'b1;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) used_sel = used_q[w];
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        logic [NUM_WORDS-1:0] column;
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            assign column[w] = SECRET[w*DATA_W + b];
        end
        svlt_lut_bit #(
            .NUM_WORDS(NUM_WORDS)
        ) u_lut (
            .column_i(column),
            .used_i  (used_sel),
            .idx_i   (idx),
            .bit_o   (lut_word[b])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        if (kind == ACC_GRANT) begin
            state_d.rdata = lut_word;
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (idx == IDX_W'(w)) state_d.used[w] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;

endmodule

// File: rtl/svlt_chk.sv
module svlt_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
    localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 cs_i,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 sys_mode_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic [NUM_WORDS-1:0] used_q
);

    int               off;
    logic             hit;
    logic [IDX_W-1:0] cidx;
    logic             legal_rd;

    always_comb begin
        off      = int'(addr_i) - int'(BASE_ADDR);
        hit      = (off >= 0) && (off < int'(NUM_WORDS));
        cidx     = off[IDX_W-1:0];
        legal_rd = cs_i && !wr_en_i && !sys_mode_i && hit;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> rdata_o == '0); // R7

    AST_APPMODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && sys_mode_i) |=> rdata_o == '0); // R4

    AST_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && wr_en_i) |=> rdata_o == '0); // R6

    AST_OUTSIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && !hit) |=> rdata_o == '0); // R5

    AST_REPEAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (legal_rd && used_q[cidx]) |=> rdata_o == '0); // R2

    AST_NO_STRAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !legal_rd |=> $stable(used_q)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (used_q & $past(used_q)) == $past(used_q)); // R2

    AST_ONE_FLAG_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(used_q & ~$past(used_q)) <= 1); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        !rst_ni |=> (used_q == '0 && rdata_o == '0)); // R8

endmodule

bind secret_vault svlt_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_WORDS(NUM_WORDS),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .sys_mode_i(sys_mode_i),
    .rdata_o   (rdata_o),
    .used_q    (used_q)
);

// File: tb/secret_vault_test.sv
module secret_vault_test;

    localparam logic [255:0] TB_SECRET =
        256'hF00D_CAFE_8BAD_F00D_DEAD_BEEF_1357_9BDF_A5A5_5A5A_0246_8ACE_C001_D00D_7E57_AB1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        mode = 1'b0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit used_m [8];

    logic [31:0] exp_q [$];
    string       req_q [$];

    always #2 clk = ~clk;

    secret_vault #(.SECRET(TB_SECRET)) uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cs_i      (cs),
        .wr_en_i   (we),
        .addr_i    (addr),
        .sys_mode_i(mode),
        .rdata_o   (rdata)
    );

    function automatic logic [31:0] word_of(int i);
        return TB_SECRET[i*32 +: 32];
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one access and push the expected next-cycle result.
    task automatic step(bit c, bit w, logic [7:0] a, bit m, string req);
        logic [31:0] e;
        int          o;
        @(negedge clk);
        cs = c; we = w; addr = a; mode = m;
        o = int'(a) - 16;
        e = '0;
        if (c && !w && !m && o >= 0 && o < 8) begin
            if (!used_m[o]) e = word_of(o);
            used_m[o] = 1'b1;
        end
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic drain();
        @(negedge clk);
        cs = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        foreach (used_m[i]) used_m[i] = 1'b0;
        check(rdata, 32'h0, "R8 reset state");
    endtask

    // Monitor: compare each result one edge after its access.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            check(rdata, exp_q.pop_front(), req_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R7 idle cycles
        step(0, 0, 8'h10, 0, "R7 idle");
        step(0, 0, 8'h13, 0, "R7 idle");
        // R4 application mode does not consume the word
        step(1, 0, 8'h13, 1, "R4 app-mode read");
        step(1, 0, 8'h13, 0, "R4 word still available");
        // R9 / R1 arbitrary order
        step(1, 0, 8'h15, 0, "R9 order word5");
        step(1, 0, 8'h10, 0, "R1 word0");
        step(1, 0, 8'h17, 0, "R1 word7");
        step(1, 0, 8'h11, 0, "R9 order word1");
        step(1, 0, 8'h16, 0, "R9 order word6");
        step(1, 0, 8'h12, 0, "R9 order word2");
        step(1, 0, 8'h14, 0, "R9 order word4");
        // R2 repeats
        step(1, 0, 8'h10, 0, "R2 repeat word0");
        step(1, 0, 8'h17, 0, "R2 repeat word7");
        // R5 outside the window
        step(1, 0, 8'h0F, 0, "R5 below window");
        step(1, 0, 8'h18, 0, "R5 above window");
        step(1, 0, 8'h00, 0, "R5 zero address");
        step(1, 0, 8'hFF, 0, "R5 top address");
        // R6 write
        step(1, 1, 8'h10, 0, "R6 write in range");
        drain();

        do_reset();
        // R3 chip select held high
        step(1, 0, 8'h12, 0, "R3 held cs first");
        step(1, 0, 8'h12, 0, "R3 held cs second");
        step(1, 0, 8'h12, 0, "R3 held cs third");
        // R6 write leaves flag clear
        step(1, 1, 8'h14, 0, "R6 write no flag");
        step(1, 0, 8'h14, 0, "R6 word4 after write");
        // R5 aliased addresses leave flags clear
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 8'h18 + 8'(k), 0, "R5 alias high");
            step(1, 0, 8'h08 + 8'(k), 0, "R5 alias low");
        end
        step(1, 0, 8'h15, 0, "R5 word5 after alias");
        step(1, 0, 8'h10, 0, "R8 re-enabled word0");
        step(1, 0, 8'h17, 1, "R4 app-mode word7");
        step(1, 0, 8'h17, 0, "R4 word7 after app-mode");
        drain();

        do_reset();
        for (int k = 7; k >= 0; k--) step(1, 0, 8'h10 + 8'(k), 0, "R8 all words after reset");
        for (int k = 0; k < 8; k++) step(1, 0, 8'h10 + 8'(k), 0, "R2 all repeats zero");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule